// File: doc/BRIEF.md
# Hot-Plug Edge-Triggered Interrupt Generator

This block sits in a PCIe downstream port and decides when the port should send an edge-triggered MSI or MSI-X interrupt message for hot-plug activity. It reduces several inputs to one compound "interrupt wanted" condition. The inputs are whether the port uses edge-triggered message signalling, the vector mask bit and whether per-vector masking exists at all, the global hot-plug interrupt enable, and a group of event status bits, each with its own enable bit. A message request is raised only when that condition moves from FALSE to TRUE.

The request comes out as a valid signal that stays high until a downstream consumer accepts it with a ready handshake. The consumer builds and sends the actual message. Only one request can be outstanding at a time. Further FALSE-to-TRUE transitions that arrive while a request is waiting merge into that request and are not counted separately.

Top module: `hp_msi_trigger`

## Requirements
- R1: No message is requested while `edge_mode` is 0, whatever the other inputs are. Setting it to 1 while all other conditions hold requests a message.
- R2: When `pvm_cap` is 1, a `vec_mask` value of 1 blocks requests. Clearing `vec_mask` while all other conditions hold requests a message.
- R3: When `pvm_cap` is 0, `vec_mask` has no effect, and a request is made even with `vec_mask` at 1.
- R4: No message is requested while `hp_int_en` is 0. Setting it to 1 while all other conditions hold requests a message.
- R5: The event part of the condition is true only when some index i has both `evt_status[i]` and `evt_enable[i]` at 1. Index 0 is attention button, 1 is power fault, 2 is presence detect, 3 is command completed and 4 is link state changed. A status bit whose own enable bit is 0 does not count, even if other enable bits are 1.
- R6: Exactly one request is made for each FALSE-to-TRUE transition of the compound condition. While the condition stays TRUE, no further request is made. A new request needs the condition to go FALSE and then TRUE again.
- R7: Once raised, `msg_valid` stays at 1 until a clock edge at which `msg_ready` is 1, and it is 0 after that edge unless a new transition occurs in the same cycle.
- R8: A transition that occurs while a request is pending and not being accepted does not queue a second request. After the pending request is accepted, `msg_valid` stays 0.
- R9: During reset `msg_valid` is 0 and the stored condition is FALSE. A condition that is already TRUE when reset is released produces exactly one request.
- R10: `msg_valid` rises on the first clock edge at which the compound condition is sampled TRUE after being FALSE on the previous edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| edge_mode | input | 1 | Port uses edge-triggered message interrupts |
| pvm_cap | input | 1 | Per-vector masking is supported |
| vec_mask | input | 1 | Mask bit of the associated vector |
| hp_int_en | input | 1 | Global hot-plug interrupt enable |
| evt_status | input | NUM_EVENTS | Hot-plug event status bits |
| evt_enable | input | NUM_EVENTS | Per-event enable bits |
| msg_ready | input | 1 | Downstream accepts the pending request |
| msg_valid | output | 1 | Message request pending |

## Verification
The bench holds the condition TRUE for many cycles after a request has been accepted. A level-sensitive design would request again here, and one that never clears its history would stop responding for good. It raises a second transition while a request is still waiting, which catches a design that queues a duplicate or drops the pending request. It sets the mask bit with per-vector masking both present and absent, which exposes a design that ignores the capability flag. It also holds the condition TRUE across reset release, which fails a design whose stored condition resets to TRUE.

// File: rtl/hp_msi_pkg.sv
package hp_msi_pkg;
   // Event index positions used by status/enable vectors
   typedef enum int unsigned {
      HP_EV_ATTN      = 0,
      HP_EV_PWR_FAULT = 1,
      HP_EV_PRESENCE  = 2,
      HP_EV_CMD_DONE  = 3,
      HP_EV_LINK_CHG  = 4
   } hp_event_e;

   localparam int unsigned HP_DEFAULT_EVENTS = 5;
   localparam int unsigned HP_MAX_EVENTS     = 32;
endpackage

// File: rtl/hp_cond_eval.sv
module hp_cond_eval #(
   parameter int unsigned NUM_EVENTS = hp_msi_pkg::HP_DEFAULT_EVENTS
) (
   input  logic                  edge_mode,
   input  logic                  pvm_cap,
   input  logic                  vec_mask,
   input  logic                  hp_int_en,
   input  logic [NUM_EVENTS-1:0] evt_status,
   input  logic [NUM_EVENTS-1:0] evt_enable,
   output logic                  cond
);
   logic [NUM_EVENTS-1:0] hit;
   logic                  any_hit;
   logic                  unmasked;

   generate
      for (genvar gi = 0; gi < NUM_EVENTS; gi++) begin : g_pair
         assign hit[gi] = evt_status[gi] & evt_enable[gi];
      end
   endgenerate

   assign any_hit  = |hit;
   // mask only counts when the capability exists
   assign unmasked = ~(pvm_cap & vec_mask);
   assign cond     = edge_mode & unmasked & hp_int_en & any_hit;
endmodule

// File: rtl/hp_edge_det.sv
module hp_edge_det (
   input  logic clk,
   input  logic rst_n,
   input  logic level_in,
   output logic level_q,
   output logic rise
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) level_q <= 1'b0;
      else        level_q <= level_in;
   end

   assign rise = level_in & ~level_q;
endmodule

// File: rtl/hp_msg_pend.sv
module hp_msg_pend (
   input  logic clk,
   input  logic rst_n,
   input  logic set,
   input  logic ready,
   output logic valid
);
   logic valid_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   valid_q <= 1'b0;
      else if (set) valid_q <= 1'b1;
      else if (ready) valid_q <= 1'b0;
   end

   assign valid = valid_q;
endmodule

// File: rtl/hp_msi_trigger.sv
module hp_msi_trigger #(
   parameter int unsigned NUM_EVENTS = hp_msi_pkg::HP_DEFAULT_EVENTS
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  edge_mode,
   input  logic                  pvm_cap,
   input  logic                  vec_mask,
   input  logic                  hp_int_en,
   input  logic [NUM_EVENTS-1:0] evt_status,
   input  logic [NUM_EVENTS-1:0] evt_enable,
   input  logic                  msg_ready,
   output logic                  msg_valid
);
   generate
      if (NUM_EVENTS < 1 || NUM_EVENTS > hp_msi_pkg::HP_MAX_EVENTS) begin : g_bad_cfg
         $error("hp_msi_trigger: NUM_EVENTS out of range");
      end
   endgenerate

   logic cond_now;
   logic cond_q;
   logic cond_rise;

   hp_cond_eval #(.NUM_EVENTS(NUM_EVENTS)) u_eval (
      .edge_mode  (edge_mode),
      .pvm_cap    (pvm_cap),
      .vec_mask   (vec_mask),
      .hp_int_en  (hp_int_en),
      .evt_status (evt_status),
      .evt_enable (evt_enable),
      .cond       (cond_now)
   );

   hp_edge_det u_edge (
      .clk      (clk),
      .rst_n    (rst_n),
      .level_in (cond_now),
      .level_q  (cond_q),
      .rise     (cond_rise)
   );

   hp_msg_pend u_pend (
      .clk   (clk),
      .rst_n (rst_n),
      .set   (cond_rise),
      .ready (msg_ready),
      .valid (msg_valid)
   );
endmodule

// File: rtl/hp_msi_trigger_chk.sv
module hp_msi_trigger_chk (
   input logic clk,
   input logic rst_n,
   input logic edge_mode,
   input logic pvm_cap,
   input logic vec_mask,
   input logic hp_int_en,
   input logic msg_ready,
   input logic msg_valid,
   input logic cond_now,
   input logic cond_q
);
   // R10: a sampled FALSE->TRUE step raises the request next cycle
   p_rise_raises_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (cond_now && !cond_q) |=> msg_valid);

   // R7: request held until accepted
   p_hold_until_ready_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (msg_valid && !msg_ready) |=> msg_valid);

   // R7: accepted without a new step drops the request
   p_accept_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (msg_valid && msg_ready && !(cond_now && !cond_q)) |=> !msg_valid);

   // R6: a request only appears after a step of the condition
   p_rise_needs_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(msg_valid) |-> $past(cond_now && !cond_q));

   // R1: edge mode off keeps an idle output idle
   p_edge_mode_gate_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (!edge_mode && !msg_valid) |=> !msg_valid);

   // R2: masked vector with masking support keeps idle output idle
   p_mask_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (pvm_cap && vec_mask && !msg_valid) |=> !msg_valid);

   // R4: global enable off keeps idle output idle
   p_enable_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!hp_int_en && !msg_valid) |=> !msg_valid);
endmodule

bind hp_msi_trigger hp_msi_trigger_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .edge_mode (edge_mode),
   .pvm_cap   (pvm_cap),
   .vec_mask  (vec_mask),
   .hp_int_en (hp_int_en),
   .msg_ready (msg_ready),
   .msg_valid (msg_valid),
   .cond_now  (cond_now),
   .cond_q    (cond_q)
);

// File: tb/hp_msi_trigger_bench.sv
module hp_msi_trigger_bench;
   localparam int unsigned NEV = 5;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           edge_mode = 1'b0;
   logic           pvm_cap = 1'b0;
   logic           vec_mask = 1'b0;
   logic           hp_int_en = 1'b0;
   logic [NEV-1:0] evt_status = '0;
   logic [NEV-1:0] evt_enable = '0;
   logic           msg_ready = 1'b0;
   logic           msg_valid;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   hp_msi_trigger #(.NUM_EVENTS(NEV)) u_hp_msi_trigger (
      .clk(clk), .rst_n(rst_n), .edge_mode(edge_mode), .pvm_cap(pvm_cap),
      .vec_mask(vec_mask), .hp_int_en(hp_int_en), .evt_status(evt_status),
      .evt_enable(evt_enable), .msg_ready(msg_ready), .msg_valid(msg_valid)
   );

   task automatic chk(input string req, input logic act, input logic exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: msg_valid=%b expected %b at %0t", req, act, exp, $time);
      end
   endtask

   task automatic step(); @(negedge clk); endtask

   task automatic accept();
      msg_ready = 1'b1; step(); msg_ready = 1'b0;
   endtask

   // drive every condition TRUE except events, then settle FALSE
   task automatic idle_all_on();
      edge_mode = 1; pvm_cap = 0; vec_mask = 0; hp_int_en = 1;
      evt_status = '0; evt_enable = '1; step(); step();
   endtask

   task automatic t_basic();
      idle_all_on();
      evt_status = 5'b00001; evt_enable = 5'b00001;
      chk("R10 before edge", msg_valid, 1'b0);
      step();
      chk("R10 raised", msg_valid, 1'b1);
      for (int i = 0; i < 3; i++) begin step(); chk("R7 held", msg_valid, 1'b1); end
      accept();
      chk("R7 cleared", msg_valid, 1'b0);
      for (int i = 0; i < 4; i++) begin step(); chk("R6 no repeat", msg_valid, 1'b0); end
      evt_status = '0; step(); step();
      chk("R6 false again", msg_valid, 1'b0);
      evt_status = 5'b00001; step();
      chk("R6 retrigger", msg_valid, 1'b1);
      accept();
   endtask

   task automatic t_mask();
      idle_all_on();
      pvm_cap = 1; vec_mask = 1; evt_status = 5'b00100;
      for (int i = 0; i < 3; i++) begin step(); chk("R2 masked", msg_valid, 1'b0); end
      vec_mask = 0; step();
      chk("R2 unmasked", msg_valid, 1'b1);
      accept();
      evt_status = '0; step(); step();
      pvm_cap = 0; vec_mask = 1; evt_status = 5'b00100; step();
      chk("R3 mask ignored", msg_valid, 1'b1);
      accept();
   endtask

   task automatic t_gate();
      idle_all_on();
      edge_mode = 0; evt_status = 5'b00010;
      for (int i = 0; i < 3; i++) begin step(); chk("R1 gated", msg_valid, 1'b0); end
      edge_mode = 1; step();
      chk("R1 enabled", msg_valid, 1'b1);
      accept();
      evt_status = '0; hp_int_en = 0; step(); step();
      evt_status = 5'b00010;
      for (int i = 0; i < 3; i++) begin step(); chk("R4 gated", msg_valid, 1'b0); end
      hp_int_en = 1; step();
      chk("R4 enabled", msg_valid, 1'b1);
      accept();
   endtask

   task automatic t_pairs();
      idle_all_on();
      evt_enable = '0; evt_status = '1;
      step(); step(); chk("R5 no enables", msg_valid, 1'b0);
      evt_status = 5'b10101; evt_enable = 5'b01010;
      step(); step(); chk("R5 mismatched pairs", msg_valid, 1'b0);
      evt_enable = 5'b11010; step();
      chk("R5 pair 4", msg_valid, 1'b1);
      accept();
      for (int i = 0; i < NEV; i++) begin
         evt_status = '0; evt_enable = '0; step(); step();
         evt_status = NEV'(1) << i; evt_enable = NEV'(1) << i; step();
         chk("R5 single pair", msg_valid, 1'b1);
         accept();
      end
   endtask

   task automatic t_pend();
      idle_all_on();
      evt_status = 5'b01000; step();
      chk("R8 first", msg_valid, 1'b1);
      evt_status = '0; step();
      evt_status = 5'b01000; step();
      chk("R8 still one pending", msg_valid, 1'b1);
      accept();
      chk("R8 accepted", msg_valid, 1'b0);
      for (int i = 0; i < 3; i++) begin step(); chk("R8 no queued", msg_valid, 1'b0); end
   endtask

   task automatic t_reset();
      rst_n = 0;
      edge_mode = 1; pvm_cap = 0; vec_mask = 0; hp_int_en = 1;
      evt_status = 5'b00001; evt_enable = 5'b00001;
      step(); step();
      chk("R9 reset low", msg_valid, 1'b0);
      rst_n = 1; step();
      chk("R9 true at release", msg_valid, 1'b1);
      accept();
      for (int i = 0; i < 3; i++) begin step(); chk("R9 exactly one", msg_valid, 1'b0); end
   endtask

   initial begin
      step(); step();
      chk("R9 reset state", msg_valid, 1'b0);
      rst_n = 1; step();
      chk("R9 idle after reset", msg_valid, 1'b0);
      t_basic();
      t_mask();
      t_gate();
      t_pairs();
      t_pend();
      t_reset();
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog: run did not complete");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule